// File: doc/BRIEF.md
# Multi-mode I/Q serial output formatter

This block turns parallel baseband sample words into serial bit streams on up to eight data pins, most significant bit first. Four sample words enter together: I and Q of a channel A and I and Q of a channel B. Each time the valid flag is high, they are captured into a pending store. That store moves into the shift path only when a frame starts, so a frame never carries a mix of old and new words.

A two-bit mode input chooses how the shift path maps onto the pins. In dual mode each of the four components gets its own pin. In single mode only channel A is sent, and each of its components is split across two pins. In wide mode channel A I and Q are each split across four pins, which uses pins 4 to 7 as well. With the same word length, wide mode needs half the bit clocks per word.

A divider made from the input clock sets the bit clock. A position counter counts bit clocks within each frame, and a one-bit-clock frame strobe can be placed up to three bit clocks ahead of the frame start. An external sync pulse puts the divider and the frame position back to a known phase.

Top module: `iq_serial_fmt`

## Requirements
- R1: The effective word length is wlen_i clamped to the range 4 to 25. Sample bits are taken from the low end of each input word. Each word is sent MSB first, and every bit position at or beyond the effective length drives 0 until the next frame load.
- R2: In dual mode (mode_i = 0, and also for the unused code 3), pin 0 carries channel A I, pin 1 channel B I, pin 2 channel A Q and pin 3 channel B Q, one bit per bit clock. Pins 4 to 7 drive 0.
- R3: In single mode (mode_i = 1), pin 0 carries A I bits MSB, MSB-2, … and pin 1 carries A I bits MSB-1, MSB-3, …. Pins 2 and 3 carry A Q in the same way. When the word length is odd, the final group is padded with 0, and pins 4 to 7 drive 0.
- R4: In wide mode (mode_i = 2), pins 0 to 3 carry four consecutive A I bits per bit clock, starting at MSB, MSB-1, MSB-2 and MSB-3. Pins 4 to 7 carry A Q in the same way.
- R5: One bit clock lasts clkdiv_i+1 input clock cycles. The pin values change only at bit clock boundaries.
- R6: A frame lasts flen_i bit clocks, and a value of 0 behaves as 1. The four words are captured on each valid cycle, and the last capture wins. The captured words take effect only at the next frame start.
- R7: frame_o is high for exactly one bit clock per frame. That bit clock is the one (adv_i mod frame length) bit clocks before the frame start, or the first bit clock of the frame when that remainder is 0.
- R8: A sync_i pulse sets the divider and the frame position to zero on the next edge and starts a new frame there, loading the captured words.
- R9: During reset all pins drive 0 and the frame position is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Resynchronizing pulse for divider and frame |
| mode_i | input | 2 | Pin mapping: 0 dual, 1 single, 2 wide |
| wlen_i | input | 5 | Serial word length in bits |
| flen_i | input | 6 | Frame interval in bit clocks |
| adv_i | input | 2 | Frame strobe advance in bit clocks |
| clkdiv_i | input | 4 | Bit clock divider, ratio is value+1 |
| samp_valid_i | input | 1 | Capture the four sample words |
| ai_i | input | 25 | Channel A in-phase word |
| bi_i | input | 25 | Channel B in-phase word |
| aq_i | input | 25 | Channel A quadrature word |
| bq_i | input | 25 | Channel B quadrature word |
| ser_o | output | 8 | Serial data pins |
| frame_o | output | 1 | Frame strobe |

## Verification
Two cases are hard to reach from the ports. The first is a strobe advance larger than a short frame, where the strobe must wrap inside the interval. The second is a new sample that arrives mid-frame, where the frame being sent must keep its old words. The directed tests use a sync pulse with a divider ratio of one, so every later cycle is a known bit position. That lets the bench place samples, advances and frame lengths at exact slots. Long runs with changing modes, dividers and frame lengths, some changed without a resync, are then compared on every cycle against a behavioural model that counts bits consumed.

// File: rtl/iq_fmt_pkg.sv
package iq_fmt_pkg;

  typedef enum logic [1:0] {
    MODE_DUAL   = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_WIDE   = 2'd2,
    MODE_RSVD   = 2'd3
  } fmt_mode_e;

  // bits of one component that leave per bit clock
  function automatic int unsigned bits_per_tick(logic [1:0] m);
    case (m)
      2'd1:    return 2;
      2'd2:    return 4;
      default: return 1;
    endcase
  endfunction

  // effective serial word length
  function automatic int unsigned clamp_len(int unsigned wl, int unsigned maxw);
    if (wl < 4) return 4;
    if (wl > maxw) return maxw;
    return wl;
  endfunction

  // last bit position of a frame; a zero interval acts as one
  function automatic int unsigned last_slot(int unsigned fl);
    return (fl == 0) ? 0 : fl - 1;
  endfunction

  // bit position that carries the strobe, advance wrapped in the interval
  function automatic int unsigned strobe_slot(int unsigned fl, int unsigned adv);
    int unsigned f;
    int unsigned a;
    f = (fl == 0) ? 1 : fl;
    a = adv % f;
    return (a == 0) ? 0 : f - a;
  endfunction

endpackage

// File: rtl/iq_fmt_lane.sv
module iq_fmt_lane
  import iq_fmt_pkg::*;
#(
  parameter int unsigned SAMP_W = 25,
  parameter int unsigned WLEN_W = 5,
  parameter int unsigned TAP    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [2:0]        step,
  input  logic [WLEN_W-1:0] wlen,
  input  logic [SAMP_W-1:0] word,
  output logic [TAP-1:0]    head
);

  logic [SAMP_W-1:0] sh;
  logic [SAMP_W-1:0] mask;
  logic [SAMP_W-1:0] aligned;
  int unsigned       wl;

  // left-align the sample so its MSB sits at the top of the register
  always_comb begin
    wl      = clamp_len(32'(wlen), SAMP_W);
    mask    = {SAMP_W{1'b1}} >> (SAMP_W - wl);
    aligned = (word & mask) << (SAMP_W - wl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh <= '0;
    else if (load)  sh <= aligned;
    else if (shift) sh <= sh << step;
  end

  assign head = sh[SAMP_W-1 -: TAP];

endmodule

// File: rtl/iq_fmt_timing.sv
module iq_fmt_timing
  import iq_fmt_pkg::*;
#(
  parameter int unsigned FLEN_W = 6,
  parameter int unsigned ADV_W  = 2,
  parameter int unsigned DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic [DIV_W-1:0]  clkdiv,
  input  logic [FLEN_W-1:0] flen,
  input  logic [ADV_W-1:0]  adv,
  output logic              bit_tick,
  output logic              frame_load,
  output logic              shift_now,
  output logic              frame_o,
  output logic [FLEN_W-1:0] pos,
  output logic [DIV_W-1:0]  div_cnt
);

  logic [FLEN_W-1:0] last;
  logic [FLEN_W-1:0] slot;
  logic              wrap;

  always_comb begin
    last = FLEN_W'(last_slot(32'(flen)));
    slot = FLEN_W'(strobe_slot(32'(flen), 32'(adv)));
  end

  assign bit_tick   = (div_cnt == clkdiv);
  assign wrap       = bit_tick && (pos >= last);
  assign frame_load = sync_i || wrap;
  assign shift_now  = bit_tick && !wrap && !sync_i;
  assign frame_o    = (pos == slot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      pos     <= '0;
    end else if (sync_i) begin
      div_cnt <= '0;
      pos     <= '0;
    end else if (bit_tick) begin
      div_cnt <= '0;
      pos     <= wrap ? '0 : pos + 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/iq_fmt_pinmux.sv
module iq_fmt_pinmux
  import iq_fmt_pkg::*;
#(
  parameter int unsigned TAP = 4
) (
  input  logic [1:0]       mode,
  input  logic [TAP-1:0]   head_ai,
  input  logic [TAP-1:0]   head_bi,
  input  logic [TAP-1:0]   head_aq,
  input  logic [TAP-1:0]   head_bq,
  output logic [2*TAP-1:0] ser
);

  always_comb begin
    ser = '0;
    case (fmt_mode_e'(mode))
      MODE_SINGLE: begin
        ser[0] = head_ai[TAP-1];
        ser[1] = head_ai[TAP-2];
        ser[2] = head_aq[TAP-1];
        ser[3] = head_aq[TAP-2];
      end
      MODE_WIDE: begin
        for (int j = 0; j < TAP; j++) begin
          ser[j]     = head_ai[TAP-1-j];
          ser[TAP+j] = head_aq[TAP-1-j];
        end
      end
      default: begin
        ser[0] = head_ai[TAP-1];
        ser[1] = head_bi[TAP-1];
        ser[2] = head_aq[TAP-1];
        ser[3] = head_bq[TAP-1];
      end
    endcase
  end

endmodule

// File: rtl/iq_serial_fmt.sv
module iq_serial_fmt
  import iq_fmt_pkg::*;
#(
  parameter  int unsigned SAMP_W = 25,
  parameter  int unsigned WLEN_W = 5,
  parameter  int unsigned FLEN_W = 6,
  parameter  int unsigned ADV_W  = 2,
  parameter  int unsigned DIV_W  = 4,
  localparam int unsigned TAP    = 4,
  localparam int unsigned NPIN   = 2 * TAP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic [1:0]        mode_i,
  input  logic [WLEN_W-1:0] wlen_i,
  input  logic [FLEN_W-1:0] flen_i,
  input  logic [ADV_W-1:0]  adv_i,
  input  logic [DIV_W-1:0]  clkdiv_i,
  input  logic              samp_valid_i,
  input  logic [SAMP_W-1:0] ai_i,
  input  logic [SAMP_W-1:0] bi_i,
  input  logic [SAMP_W-1:0] aq_i,
  input  logic [SAMP_W-1:0] bq_i,
  output logic [NPIN-1:0]   ser_o,
  output logic              frame_o
);

  localparam int unsigned NLANE = 4;

  logic [SAMP_W-1:0] word_in [NLANE];
  logic [SAMP_W-1:0] pend    [NLANE];
  logic [TAP-1:0]    head    [NLANE];

  logic              bit_tick;
  logic              frame_load;
  logic              shift_now;
  logic [FLEN_W-1:0] frame_pos;
  logic [DIV_W-1:0]  div_cnt;
  logic [2:0]        step;

  assign word_in[0] = ai_i;
  assign word_in[1] = bi_i;
  assign word_in[2] = aq_i;
  assign word_in[3] = bq_i;
  assign step       = 3'(bits_per_tick(mode_i));

  iq_fmt_timing #(
    .FLEN_W (FLEN_W),
    .ADV_W  (ADV_W),
    .DIV_W  (DIV_W)
  ) u_timing (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_i     (sync_i),
    .clkdiv     (clkdiv_i),
    .flen       (flen_i),
    .adv        (adv_i),
    .bit_tick   (bit_tick),
    .frame_load (frame_load),
    .shift_now  (shift_now),
    .frame_o    (frame_o),
    .pos        (frame_pos),
    .div_cnt    (div_cnt)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pend[g] <= '0;
      else if (samp_valid_i) pend[g] <= word_in[g];
    end

    iq_fmt_lane #(
      .SAMP_W (SAMP_W),
      .WLEN_W (WLEN_W),
      .TAP    (TAP)
    ) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (frame_load),
      .shift (shift_now),
      .step  (step),
      .wlen  (wlen_i),
      .word  (pend[g]),
      .head  (head[g])
    );
  end

  iq_fmt_pinmux #(
    .TAP (TAP)
  ) u_pinmux (
    .mode    (mode_i),
    .head_ai (head[0]),
    .head_bi (head[1]),
    .head_aq (head[2]),
    .head_bq (head[3]),
    .ser     (ser_o)
  );

endmodule

// File: rtl/iq_fmt_chk.sv
module iq_fmt_chk #(
  parameter int unsigned FLEN_W = 6,
  parameter int unsigned ADV_W  = 2,
  parameter int unsigned DIV_W  = 4,
  parameter int unsigned NPIN   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_i,
  input logic [1:0]        mode_i,
  input logic [FLEN_W-1:0] flen_i,
  input logic [ADV_W-1:0]  adv_i,
  input logic [NPIN-1:0]   ser_o,
  input logic              frame_o,
  input logic              bit_tick,
  input logic [FLEN_W-1:0] frame_pos,
  input logic [DIV_W-1:0]  div_cnt
);

  // R8: a sync pulse zeroes divider phase and frame position
  a_r8_sync_phase: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> (div_cnt == '0 && frame_pos == '0));

  // R5: a bit clock boundary restarts the divider
  a_r5_tick_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !sync_i) |=> (div_cnt == '0));

  // R5: pins hold between bit clock boundaries
  a_r5_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_i && !bit_tick) |=> ($stable(ser_o) || !$stable(mode_i)));

  // R7: strobe holds between bit clock boundaries
  a_r7_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_i && !bit_tick) |=>
      ($stable(frame_o) || !$stable(adv_i) || !$stable(flen_i)));

  // R2 and R3: only the wide mapping drives the upper pins
  a_r2_upper_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 2'd2) |-> (ser_o[NPIN-1:NPIN/2] == '0));

  // R6: a one-bit-clock frame keeps position zero
  a_r6_unit_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (flen_i <= 1 && $stable(flen_i) && $past(frame_pos) == '0) |-> (frame_pos == '0));

endmodule

bind iq_serial_fmt iq_fmt_chk #(
  .FLEN_W (FLEN_W),
  .ADV_W  (ADV_W),
  .DIV_W  (DIV_W),
  .NPIN   (NPIN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sync_i    (sync_i),
  .mode_i    (mode_i),
  .flen_i    (flen_i),
  .adv_i     (adv_i),
  .ser_o     (ser_o),
  .frame_o   (frame_o),
  .bit_tick  (bit_tick),
  .frame_pos (frame_pos),
  .div_cnt   (div_cnt)
);

// File: tb/iq_serial_fmt_tb.sv
module iq_serial_fmt_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [4:0]  wlen_i = 5'd4;
  logic [5:0]  flen_i = 6'd8;
  logic [1:0]  adv_i = 2'd0;
  logic [3:0]  clkdiv_i = 4'd0;
  logic        samp_valid_i = 1'b0;
  logic [24:0] ai_i = '0, bi_i = '0, aq_i = '0, bq_i = '0;
  logic [7:0]  ser_o;
  logic        frame_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  iq_serial_fmt u_dut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .mode_i(mode_i),
    .wlen_i(wlen_i), .flen_i(flen_i), .adv_i(adv_i), .clkdiv_i(clkdiv_i),
    .samp_valid_i(samp_valid_i), .ai_i(ai_i), .bi_i(bi_i), .aq_i(aq_i),
    .bq_i(bq_i), .ser_o(ser_o), .frame_o(frame_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_div = 0, m_pos = 0, m_cons = 0, m_wl = 0;
  int m_w[4];
  int m_pend[4];

  function automatic int eff_len(int w);
    if (w < 4) return 4;
    if (w > 25) return 25;
    return w;
  endfunction

  function automatic int per_tick(int m);
    if (m == 1) return 2;
    if (m == 2) return 4;
    return 1;
  endfunction

  function automatic int mbit(int c, int k);
    if (k < m_wl) return (m_w[c] >> (m_wl - 1 - k)) & 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_pos = 0; m_cons = 0; m_wl = 4;
      for (int c = 0; c < 4; c++) begin m_w[c] = 0; m_pend[c] = 0; end
    end else begin
      int fl;
      bit ld;
      fl = (flen_i == 0) ? 1 : int'(flen_i);
      ld = 0;
      if (sync_i) begin
        m_div = 0; m_pos = 0; ld = 1;
      end else if (m_div == int'(clkdiv_i)) begin
        m_div = 0;
        if (m_pos >= fl - 1) begin m_pos = 0; ld = 1; end
        else begin m_pos++; m_cons += per_tick(int'(mode_i)); end
      end else begin
        m_div++;
      end
      if (ld) begin
        for (int c = 0; c < 4; c++) m_w[c] = m_pend[c];
        m_wl = eff_len(int'(wlen_i));
        m_cons = 0;
      end
      if (samp_valid_i) begin
        m_pend[0] = int'(ai_i); m_pend[1] = int'(bi_i);
        m_pend[2] = int'(aq_i); m_pend[3] = int'(bq_i);
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic [7:0] e;
      int fl;
      int slot;
      e = '0;
      if (mode_i == 2'd1) begin
        e[0] = mbit(0, m_cons)[0]; e[1] = mbit(0, m_cons + 1)[0];
        e[2] = mbit(2, m_cons)[0]; e[3] = mbit(2, m_cons + 1)[0];
        check("R3 model", int'(ser_o), int'(e));
      end else if (mode_i == 2'd2) begin
        for (int j = 0; j < 4; j++) begin
          e[j] = mbit(0, m_cons + j)[0];
          e[4+j] = mbit(2, m_cons + j)[0];
        end
        check("R4 model", int'(ser_o), int'(e));
      end else begin
        for (int j = 0; j < 4; j++) e[j] = mbit(j, m_cons)[0];
        check("R2 model", int'(ser_o), int'(e));
      end
      fl = (flen_i == 0) ? 1 : int'(flen_i);
      slot = (fl - (int'(adv_i) % fl)) % fl;
      check("R7 model", int'(frame_o), int'(m_pos == slot));
    end
  end

  // ---------------- directed helpers ----------------
  logic [7:0] snap [16];
  logic       fsnap [16];

  task automatic cfg(int m, int wl, int fl, int adv, int dv);
    @(negedge clk);
    mode_i = 2'(m); wlen_i = 5'(wl); flen_i = 6'(fl);
    adv_i = 2'(adv); clkdiv_i = 4'(dv);
  endtask

  task automatic load_words(int a, int b, int c, int d);
    @(negedge clk);
    ai_i = 25'(a); bi_i = 25'(b); aq_i = 25'(c); bq_i = 25'(d);
    samp_valid_i = 1'b1;
    @(negedge clk);
    samp_valid_i = 1'b0;
  endtask

  task automatic do_sync();
    sync_i = 1'b1;
    @(negedge clk);
    sync_i = 1'b0;
  endtask

  task automatic collect(int n);
    for (int i = 0; i < n; i++) begin
      snap[i] = ser_o; fsnap[i] = frame_o;
      @(negedge clk);
    end
  endtask

  function automatic int pin_vec(int pin, int n);
    int v = 0;
    for (int i = 0; i < n; i++) v = (v << 1) | int'(snap[i][pin]);
    return v;
  endfunction

  function automatic int frame_vec(int n);
    int v = 0;
    for (int i = 0; i < n; i++) v = (v << 1) | int'(fsnap[i]);
    return v;
  endfunction

  logic [31:0] lf = 32'h1d2c_3b4a;
  function automatic logic [31:0] next_lf(logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hi, lo;
    repeat (3) @(negedge clk);
    check("R9 reset pins", int'(ser_o), 0);
    check("R9 reset strobe at position 0", int'(frame_o), 1);
    rst_n = 1'b1;

    // R2 and R1: dual mapping, four-bit words in an eight-bit frame
    cfg(0, 4, 8, 0, 0);
    load_words('hA, 'h5, 'hF, 'h0);
    do_sync();
    collect(8);
    check("R2 pin0 A I", pin_vec(0, 8), 'hA0);
    check("R2 pin1 B I", pin_vec(1, 8), 'h50);
    check("R2 pin2 A Q", pin_vec(2, 8), 'hF0);
    check("R2 pin3 B Q", pin_vec(3, 8), 'h00);
    check("R1 zero after last bit", pin_vec(0, 8) & 'h0F, 0);

    // R1: length below the minimum acts as four
    cfg(0, 2, 4, 0, 0);
    load_words('h9, 0, 0, 0);
    do_sync();
    collect(4);
    check("R1 clamp to four bits", pin_vec(0, 4), 'h9);

    // R3: single mapping with odd length and zero pad
    cfg(1, 5, 4, 0, 0);
    load_words('b10110, 'h1F, 'b01101, 'h1F);
    do_sync();
    collect(4);
    check("R3 pin0 even bits", pin_vec(0, 4), 'hC);
    check("R3 pin1 odd bits padded", pin_vec(1, 4), 'h4);
    check("R3 pin2 Q even bits", pin_vec(2, 4), 'h6);
    check("R3 pin3 Q odd bits", pin_vec(3, 4), 'h8);
    check("R3 upper pins idle", int'(snap[0][7:4]), 0);

    // R4: wide mapping, four bits per component per bit clock
    cfg(2, 6, 2, 0, 0);
    load_words('b110011, 0, 'b101101, 0);
    do_sync();
    collect(2);
    check("R4 first bit clock", int'(snap[0]), 'hD3);
    check("R4 second bit clock", int'(snap[1]), 'h23);

    // R7: advance two in a six-bit frame, and advance wrap in a short frame
    cfg(0, 4, 6, 2, 0);
    do_sync();
    collect(6);
    check("R7 strobe two early", frame_vec(6), 'b000010);
    cfg(0, 4, 2, 3, 0);
    do_sync();
    collect(2);
    check("R7 advance wraps", frame_vec(2), 'b01);

    // R6: mid-frame captures wait for the next frame, last one wins
    cfg(0, 4, 4, 0, 0);
    load_words('hF, 0, 0, 0);
    do_sync();
    snap[0] = ser_o;
    ai_i = 25'h8; samp_valid_i = 1'b1;
    @(negedge clk);
    snap[1] = ser_o;
    ai_i = 25'h0;
    @(negedge clk);
    samp_valid_i = 1'b0;
    snap[2] = ser_o;
    @(negedge clk);
    snap[3] = ser_o;
    @(negedge clk);
    check("R6 frame keeps old word", pin_vec(0, 4), 'hF);
    collect(4);
    check("R6 next frame takes latest word", pin_vec(0, 4), 'h0);

    // R8: sync mid-frame restarts divider phase and frame
    cfg(0, 4, 10, 0, 3);
    repeat (7) @(negedge clk);
    do_sync();
    collect(5);
    check("R8 strobe after sync", int'({fsnap[0], fsnap[1], fsnap[2], fsnap[3]}), 'hF);
    check("R8 strobe ends after one bit clock", int'(fsnap[4]), 0);

    // R5: bit clock is clkdiv+1 cycles
    cfg(0, 4, 5, 0, 2);
    do_sync();
    hi = 0; lo = 0;
    while (frame_o && hi < 100) begin hi++; @(negedge clk); end
    while (!frame_o && lo < 100) begin lo++; @(negedge clk); end
    check("R5 strobe width in cycles", hi, 3);
    check("R5 frame period in cycles", hi + lo, 15);

    // mixed patterns compared against the model every cycle
    for (int p = 0; p < 9; p++) begin
      int fls[9] = '{1, 0, 63, 7, 3, 12, 2, 25, 5};
      cfg(p % 3, 4 + (p * 5) % 28, fls[p], p % 4, p % 3);
      if (p % 2 == 0) do_sync();
      for (int cyc = 0; cyc < 400; cyc++) begin
        lf = next_lf(lf); ai_i = lf[24:0];
        lf = next_lf(lf); bi_i = lf[24:0];
        lf = next_lf(lf); aq_i = lf[24:0];
        lf = next_lf(lf); bq_i = lf[24:0];
        samp_valid_i = (cyc % 7 == 3);
        sync_i = (cyc == 211);
        @(negedge clk);
      end
      samp_valid_i = 1'b0;
      sync_i = 1'b0;
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule